// File: doc/BRIEF.md
# Fully Associative Address Translation Lookup

This block turns a 32-bit virtual address into a physical address, or into a fault code, for a single instruction fetch or data access. Fixed windows of the address space skip translation. The rest is compared against every entry of a parameterised, fully associative TLB whose entry fields come in on ports. Each entry is checked for validity, address-space identifier or sharing, and page range, with four page sizes. A lookup that survives matching then passes through protection and dirty checks. The block also keeps the 6-bit replacement pointer that advances on each data-side translated lookup.

A request strobe `req` samples the inputs. The result appears, registered, on the next cycle with `rsp_valid` high. A small two-state machine sequences this. `ST_IDLE` moves to `ST_RESULT` on transition `T_ACCEPT` when `req` is high. `ST_RESULT` stays in `ST_RESULT` on transition `T_CHAIN` when another `req` arrives, and returns to `ST_IDLE` on transition `T_DRAIN` otherwise. When a result carries a fault, the faulting virtual address is captured in `tea`.

Top module: `tlb_xlate`

## Requirements
- R1: When privileged (`priv_md`=1), addresses 0x80000000..0xBFFFFFFF and addresses at or above 0xE0000000 return no fault, with `rsp_pa` equal to the address with bits 31:29 cleared.
- R2: When `priv_md`=0, an address in those windows faults as a miss (0x040 for read or fetch, 0x060 for write) unless it lies in 0xE0000000..0xE4000000 inclusive, which passes through like R1.
- R3: Outside those windows, with `at_en`=0, the address passes through with bits 31:29 cleared and no fault.
- R4: An entry takes part only if its valid bit is set and either it is shared or its ASID equals `cur_asid`. ASID comparison applies only when `sv_en`=0 and `priv_md`=0; otherwise ASID is ignored.
- R5: Size code 0/1/2/3 selects 1 KB/4 KB/64 KB/1 MB pages. The page base is {vpn,10'b0} with the offset bits cleared, and the physical address is {ppn,10'b0} with the offset bits cleared, ORed with the address offset bits.
- R6: Two or more participating entries covering the address give fault code 0x140.
- R7: For a data access, the index {pr[1:0], priv_md} of the hit entry decides access: 0 and 2 deny all (0x0A0 read, 0x0C0 write); 1, 4 and 5 allow reads and deny writes (0x0C0); 3, 6 and 7 allow both.
- R8: An instruction fetch (`acc_fetch`=1, where `acc_write` is ignored) with `priv_md`=1 to an entry with pr[1]=0 gives 0x0A0; otherwise a hit fetch is allowed.
- R9: A permitted write to an entry whose dirty bit is 0 gives 0x080.
- R10: A translated lookup that no entry matches gives 0x040 for read or fetch and 0x060 for write. A faulting result has `rsp_fault`=1 and `rsp_pa`=0; a clean result has `rsp_fault`=0 and `rsp_code`=0.
- R11: `urc` resets to 0 and advances by one on each accepted data (non-fetch) lookup that goes through the TLB (`at_en`=1, outside the R1 windows). It becomes 0 instead when the next value would equal `urb` or 63. It holds otherwise.
- R12: `rsp_valid` is high exactly in the cycle after a cycle with `req` high, and results are held between requests. `tea` loads the request address when that request faults and holds otherwise. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Lookup request strobe |
| va | input | 32 | Virtual address |
| acc_fetch | input | 1 | 1 = instruction fetch |
| acc_write | input | 1 | 1 = data write (ignored on fetch) |
| priv_md | input | 1 | 1 = privileged mode |
| at_en | input | 1 | Translation enable |
| sv_en | input | 1 | Single-address-space mode (ASID ignored) |
| cur_asid | input | 8 | Current address-space identifier |
| urb | input | 6 | Replacement pointer boundary |
| ent_valid | input | N | Per-entry valid bits |
| ent_shared | input | N | Per-entry shared bits |
| ent_dirty | input | N | Per-entry dirty bits |
| ent_size | input | 2*N | Per-entry page size codes |
| ent_pr | input | 2*N | Per-entry protection codes |
| ent_asid | input | 8*N | Per-entry ASIDs |
| ent_vpn | input | 22*N | Per-entry virtual page numbers (address bits 31:10) |
| ent_ppn | input | 19*N | Per-entry physical page numbers (address bits 28:10) |
| rsp_valid | output | 1 | Result valid |
| rsp_fault | output | 1 | Result is a fault |
| rsp_code | output | 12 | Fault code, 0 when clean |
| rsp_pa | output | 32 | Physical address, 0 on fault |
| tea | output | 32 | Last faulting virtual address |
| urc | output | 6 | Replacement pointer |

## Verification
Embedded properties check several rules on every cycle: the result timing against the request strobe, the 29-bit width of clean physical addresses, the zero code on clean results, the capture of the faulting address into `tea`, and the pointer's legal range and step. The content of a result cannot be checked that way. Which entry hits, the effect of page size on range and address composition, the ASID and sharing rules, the protection table, the dirty fault and multi-hit detection only show up in the bench's lookups. There, a behavioural model computes every result and pointer value and compares it cycle by cycle, including the wrap of the pointer at 63 and at the boundary `urb`.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
    localparam int VA_W     = 32;
    localparam int PA_W     = 29;
    localparam int PAGE_LSB = 10;
    localparam int VPN_W    = VA_W - PAGE_LSB;
    localparam int PPN_W    = PA_W - PAGE_LSB;
    localparam int CODE_W   = 12;

    localparam logic [CODE_W-1:0] C_NONE      = 12'h000;
    localparam logic [CODE_W-1:0] C_MISS_RD   = 12'h040;
    localparam logic [CODE_W-1:0] C_MISS_WR   = 12'h060;
    localparam logic [CODE_W-1:0] C_FIRST_WR  = 12'h080;
    localparam logic [CODE_W-1:0] C_PROT_RD   = 12'h0A0;
    localparam logic [CODE_W-1:0] C_PROT_WR   = 12'h0C0;
    localparam logic [CODE_W-1:0] C_MULTI     = 12'h140;

    typedef enum logic {ST_IDLE = 1'b0, ST_RESULT = 1'b1} fsm_t;

    typedef struct packed {
        logic              fault;
        logic [CODE_W-1:0] code;
        logic [VA_W-1:0]   pa;
    } xlate_res_t;

    function automatic logic [VA_W-1:0] page_mask(input logic [1:0] sz);
        logic [VA_W-1:0] m;
        unique case (sz)
            2'd0:    m = 32'h0000_03FF;
            2'd1:    m = 32'h0000_0FFF;
            2'd2:    m = 32'h0000_FFFF;
            default: m = 32'h000F_FFFF;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/tlb_entry_cmp.sv
module tlb_entry_cmp
    import tlbx_pkg::*;
#(
    parameter int ASID_W = 8
) (
    input  logic [VA_W-1:0]   va,
    input  logic              use_asid,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic              valid,
    input  logic              shared,
    input  logic [1:0]        size,
    input  logic [ASID_W-1:0] asid,
    input  logic [VPN_W-1:0]  vpn,
    input  logic [PPN_W-1:0]  ppn,
    output logic              hit,
    output logic [PA_W-1:0]   pa
);
    logic [VA_W-1:0] off_m;
    logic [VA_W-1:0] base;
    logic [PA_W-1:0] pbase;
    logic            asid_ok;
    logic            in_page;

    always_comb begin
        off_m   = page_mask(size);
        base    = {vpn, {PAGE_LSB{1'b0}}} & ~off_m;
        pbase   = {ppn, {PAGE_LSB{1'b0}}} & ~off_m[PA_W-1:0];
        asid_ok = !use_asid || shared || (asid == cur_asid);
        in_page = ((va & ~off_m) == base);
        hit     = valid && asid_ok && in_page;
        pa      = pbase | (va[PA_W-1:0] & off_m[PA_W-1:0]);
    end
endmodule

// File: rtl/tlb_match_array.sv
module tlb_match_array
    import tlbx_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int ASID_W    = 8
) (
    input  logic [VA_W-1:0]            va,
    input  logic                       use_asid,
    input  logic [ASID_W-1:0]          cur_asid,
    input  logic [N_ENTRIES-1:0]       ent_valid,
    input  logic [N_ENTRIES-1:0]       ent_shared,
    input  logic [N_ENTRIES-1:0]       ent_dirty,
    input  logic [2*N_ENTRIES-1:0]     ent_size,
    input  logic [2*N_ENTRIES-1:0]     ent_pr,
    input  logic [ASID_W*N_ENTRIES-1:0] ent_asid,
    input  logic [VPN_W*N_ENTRIES-1:0] ent_vpn,
    input  logic [PPN_W*N_ENTRIES-1:0] ent_ppn,
    output logic                       any_hit,
    output logic                       multi_hit,
    output logic [PA_W-1:0]            sel_pa,
    output logic [1:0]                 sel_pr,
    output logic                       sel_dirty
);
    localparam int CNT_W = $clog2(N_ENTRIES + 1);

    logic [N_ENTRIES-1:0] hits;
    logic [PA_W-1:0]      pa_of [N_ENTRIES];
    logic [CNT_W-1:0]     n_hits;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
        tlb_entry_cmp #(.ASID_W(ASID_W)) u_cmp (
            .va       (va),
            .use_asid (use_asid),
            .cur_asid (cur_asid),
            .valid    (ent_valid[g]),
            .shared   (ent_shared[g]),
            .size     (ent_size[2*g +: 2]),
            .asid     (ent_asid[ASID_W*g +: ASID_W]),
            .vpn      (ent_vpn[VPN_W*g +: VPN_W]),
            .ppn      (ent_ppn[PPN_W*g +: PPN_W]),
            .hit      (hits[g]),
            .pa       (pa_of[g])
        );
    end

    always_comb begin
        n_hits    = '0;
        sel_pa    = '0;
        sel_pr    = '0;
        sel_dirty = 1'b0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            n_hits = n_hits + CNT_W'(hits[i]);
        end
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (hits[i]) begin
                sel_pa    = pa_of[i];
                sel_pr    = ent_pr[2*i +: 2];
                sel_dirty = ent_dirty[i];
            end
        end
        any_hit   = (n_hits != '0);
        multi_hit = (n_hits > CNT_W'(1));
    end
endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
    import tlbx_pkg::*;
(
    input  logic              is_fetch,
    input  logic              is_write,
    input  logic              md,
    input  logic [1:0]        pr,
    input  logic              dirty,
    output logic [CODE_W-1:0] code
);
    logic [2:0] idx;

    always_comb begin
        idx  = {pr, md};
        code = C_NONE;
        if (is_fetch) begin
            if (md && !pr[1]) code = C_PROT_RD;
        end else begin
            unique case (idx)
                3'd0, 3'd2:       code = is_write ? C_PROT_WR : C_PROT_RD;
                3'd1, 3'd4, 3'd5: code = is_write ? C_PROT_WR : C_NONE;
                default:          code = C_NONE;
            endcase
            if (code == C_NONE && is_write && !dirty) code = C_FIRST_WR;
        end
    end
endmodule

// File: rtl/tlb_urc_counter.sv
module tlb_urc_counter #(
    parameter int URC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [URC_W-1:0] urb,
    output logic [URC_W-1:0] urc
);
    localparam logic [URC_W-1:0] LIMIT = {URC_W{1'b1}};

    logic [URC_W-1:0] nxt;

    always_comb begin
        nxt = urc + 1'b1;
        if (nxt == urb || nxt == LIMIT) nxt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    urc <= '0;
        else if (step) urc <= nxt;
    end

    // R11: the pointer never rests on the all-ones value
    a_r11_never_limit: assert property (@(posedge clk) disable iff (!rst_n)
        urc != LIMIT);
    // R11: no lookup, no movement
    a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(urc));
    // R11: a lookup either advances by one or wraps to zero
    a_r11_step_or_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (urc == '0 || urc == $past(urc) + 1'b1));
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlbx_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int ASID_W    = 8,
    parameter int URC_W     = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req,
    input  logic [31:0]                 va,
    input  logic                        acc_fetch,
    input  logic                        acc_write,
    input  logic                        priv_md,
    input  logic                        at_en,
    input  logic                        sv_en,
    input  logic [ASID_W-1:0]           cur_asid,
    input  logic [URC_W-1:0]            urb,
    input  logic [N_ENTRIES-1:0]        ent_valid,
    input  logic [N_ENTRIES-1:0]        ent_shared,
    input  logic [N_ENTRIES-1:0]        ent_dirty,
    input  logic [2*N_ENTRIES-1:0]      ent_size,
    input  logic [2*N_ENTRIES-1:0]      ent_pr,
    input  logic [ASID_W*N_ENTRIES-1:0] ent_asid,
    input  logic [22*N_ENTRIES-1:0]     ent_vpn,
    input  logic [19*N_ENTRIES-1:0]     ent_ppn,
    output logic                        rsp_valid,
    output logic                        rsp_fault,
    output logic [11:0]                 rsp_code,
    output logic [31:0]                 rsp_pa,
    output logic [31:0]                 tea,
    output logic [URC_W-1:0]            urc
);
    localparam logic [VA_W-1:0] PA_MASK = {{(VA_W-PA_W){1'b0}}, {PA_W{1'b1}}};
    localparam logic [VA_W-1:0] SQ_LO   = 32'hE000_0000;
    localparam logic [VA_W-1:0] SQ_HI   = 32'hE400_0000;

    fsm_t       state, state_nxt;
    xlate_res_t res_c, res_q;

    logic              is_write;
    logic              fixed_win;
    logic              user_ok;
    logic              use_asid;
    logic              any_hit, multi_hit, sel_dirty;
    logic [PA_W-1:0]   sel_pa;
    logic [1:0]        sel_pr;
    logic [CODE_W-1:0] perm_code;
    logic [CODE_W-1:0] miss_code;
    logic              urc_step;

    always_comb begin
        is_write  = acc_write && !acc_fetch;
        fixed_win = (va[31:30] == 2'b10) || (va[31:29] == 3'b111);
        user_ok   = (va >= SQ_LO) && (va <= SQ_HI);
        use_asid  = !sv_en && !priv_md;
        miss_code = is_write ? C_MISS_WR : C_MISS_RD;
        urc_step  = req && at_en && !fixed_win && !acc_fetch;
    end

    tlb_match_array #(.N_ENTRIES(N_ENTRIES), .ASID_W(ASID_W)) u_match (
        .va         (va),
        .use_asid   (use_asid),
        .cur_asid   (cur_asid),
        .ent_valid  (ent_valid),
        .ent_shared (ent_shared),
        .ent_dirty  (ent_dirty),
        .ent_size   (ent_size),
        .ent_pr     (ent_pr),
        .ent_asid   (ent_asid),
        .ent_vpn    (ent_vpn),
        .ent_ppn    (ent_ppn),
        .any_hit    (any_hit),
        .multi_hit  (multi_hit),
        .sel_pa     (sel_pa),
        .sel_pr     (sel_pr),
        .sel_dirty  (sel_dirty)
    );

    tlb_perm_check u_perm (
        .is_fetch (acc_fetch),
        .is_write (is_write),
        .md       (priv_md),
        .pr       (sel_pr),
        .dirty    (sel_dirty),
        .code     (perm_code)
    );

    tlb_urc_counter #(.URC_W(URC_W)) u_urc (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (urc_step),
        .urb   (urb),
        .urc   (urc)
    );

    // Result selection: fixed windows, then translation-off, then TLB
    always_comb begin
        res_c = '0;
        if (fixed_win) begin
            if (!priv_md && !user_ok) res_c.code = miss_code;
            else                      res_c.pa   = va & PA_MASK;
        end else if (!at_en) begin
            res_c.pa = va & PA_MASK;
        end else if (!any_hit) begin
            res_c.code = miss_code;
        end else if (multi_hit) begin
            res_c.code = C_MULTI;
        end else begin
            res_c.code = perm_code;
            if (perm_code == C_NONE) res_c.pa = {{(VA_W-PA_W){1'b0}}, sel_pa};
        end
        res_c.fault = (res_c.code != C_NONE);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Transitions: T_ACCEPT, T_CHAIN, T_DRAIN
    always_comb begin
        unique case (state)
            ST_IDLE:   state_nxt = req ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_nxt = req ? ST_RESULT : ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // Result and faulting-address registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            tea   <= '0;
        end else if (req) begin
            res_q <= res_c;
            if (res_c.fault) tea <= va;
        end
    end

    // Output process
    always_comb begin
        rsp_valid = (state == ST_RESULT);
        rsp_fault = res_q.fault;
        rsp_code  = res_q.code;
        rsp_pa    = res_q.pa;
    end

    // R12: result appears exactly one cycle after the strobe
    a_r12_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> rsp_valid);
    a_r12_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !rsp_valid);
    // R12: a faulting result carries its address in tea
    a_r12_tea_capture: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (!rsp_fault || tea == $past(va)));
    // R1: a clean physical address never exceeds 29 bits
    a_r1_pa_width: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_pa[31:29] == 3'b000));
    // R10: clean results carry code zero, faults carry a zero address
    a_r10_code_vs_fault: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_fault && rsp_code != 12'h000 && rsp_pa == 32'h0) ||
                       (!rsp_fault && rsp_code == 12'h000)));
    // R12: result held when no new request
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> ($stable(rsp_code) && $stable(rsp_pa) && $stable(tea)));
endmodule

// File: tb/tlb_xlate_tb.sv
`timescale 1ns/1ps
module tlb_xlate_tb;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        req = 0, acc_fetch = 0, acc_write = 0, priv_md = 0;
    logic        at_en = 0, sv_en = 0;
    logic [31:0] va = '0;
    logic [7:0]  cur_asid = '0;
    logic [5:0]  urb = '0;

    logic        b_valid [N];
    logic        b_shared[N];
    logic        b_dirty [N];
    logic [1:0]  b_size  [N];
    logic [1:0]  b_pr    [N];
    logic [7:0]  b_asid  [N];
    logic [21:0] b_vpn   [N];
    logic [18:0] b_ppn   [N];

    logic [N-1:0]    ent_valid, ent_shared, ent_dirty;
    logic [2*N-1:0]  ent_size, ent_pr;
    logic [8*N-1:0]  ent_asid;
    logic [22*N-1:0] ent_vpn;
    logic [19*N-1:0] ent_ppn;

    always_comb begin
        for (int e = 0; e < N; e++) begin
            ent_valid[e]        = b_valid[e];
            ent_shared[e]       = b_shared[e];
            ent_dirty[e]        = b_dirty[e];
            ent_size[2*e +: 2]  = b_size[e];
            ent_pr[2*e +: 2]    = b_pr[e];
            ent_asid[8*e +: 8]  = b_asid[e];
            ent_vpn[22*e +: 22] = b_vpn[e];
            ent_ppn[19*e +: 19] = b_ppn[e];
        end
    end

    logic        rsp_valid, rsp_fault;
    logic [11:0] rsp_code;
    logic [31:0] rsp_pa, tea;
    logic [5:0]  urc;

    tlb_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .va(va),
        .acc_fetch(acc_fetch), .acc_write(acc_write), .priv_md(priv_md),
        .at_en(at_en), .sv_en(sv_en), .cur_asid(cur_asid), .urb(urb),
        .ent_valid(ent_valid), .ent_shared(ent_shared), .ent_dirty(ent_dirty),
        .ent_size(ent_size), .ent_pr(ent_pr), .ent_asid(ent_asid),
        .ent_vpn(ent_vpn), .ent_ppn(ent_ppn),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_code(rsp_code),
        .rsp_pa(rsp_pa), .tea(tea), .urc(urc)
    );

    int    n_cmp = 0, n_bad = 0;
    bit    done = 0;
    string cur_tag = "R12";
    string exp_tag = "R12";

    logic        e_valid = 0, e_fault = 0;
    logic [11:0] e_code = 0;
    logic [31:0] e_pa = 0, e_tea = 0;
    int          e_urc = 0;

    // Behavioural reference for one lookup
    function automatic void ref_lookup(input logic [31:0] a, input bit f, input bit w,
                                       input bit md, input bit at, input bit sv,
                                       input logic [7:0] asid,
                                       output bit flt, output logic [11:0] code,
                                       output logic [31:0] pa, output bit ustep);
        bit wr;
        int nh, idx, p;
        longint sz, start, a_l;
        wr = w && !f;
        flt = 0; code = 0; pa = 0; ustep = 0; nh = 0; idx = 0;
        a_l = longint'(a);
        if ((a_l >= 64'h8000_0000 && a_l < 64'hC000_0000) || a_l >= 64'hE000_0000) begin
            if (!md && (a_l < 64'hE000_0000 || a_l > 64'hE400_0000))
                code = wr ? 12'h060 : 12'h040;
            else
                pa = a & 32'h1FFF_FFFF;
        end else if (!at) begin
            pa = a & 32'h1FFF_FFFF;
        end else begin
            ustep = !f;
            for (int e = 0; e < N; e++) begin
                if (!b_valid[e]) continue;
                if (!sv && !md && !b_shared[e] && b_asid[e] != asid) continue;
                case (b_size[e])
                    2'd0: sz = 1024;
                    2'd1: sz = 4096;
                    2'd2: sz = 65536;
                    default: sz = 1048576;
                endcase
                start = (longint'(b_vpn[e]) * 1024) & ~(sz - 1);
                if (a_l >= start && a_l <= start + sz - 1) begin
                    nh++;
                    idx = e;
                end
            end
            if (nh == 0) code = wr ? 12'h060 : 12'h040;
            else if (nh > 1) code = 12'h140;
            else begin
                case (b_size[idx])
                    2'd0: sz = 1024;
                    2'd1: sz = 4096;
                    2'd2: sz = 65536;
                    default: sz = 1048576;
                endcase
                if (f) begin
                    if (md && !b_pr[idx][1]) code = 12'h0A0;
                end else begin
                    p = int'(b_pr[idx]) * 2 + int'(md);
                    if (p == 0 || p == 2) code = wr ? 12'h0C0 : 12'h0A0;
                    else if ((p == 1 || p == 4 || p == 5) && wr) code = 12'h0C0;
                    if (code == 0 && wr && !b_dirty[idx]) code = 12'h080;
                end
                if (code == 0)
                    pa = 32'(((longint'(b_ppn[idx]) * 1024) & ~(sz - 1)) | (a_l & (sz - 1)));
            end
        end
        flt = (code != 0);
        if (flt) pa = 0;
    endfunction

    // Model update at the sampling edge (inputs change 1 ns after each edge)
    always @(posedge clk or negedge rst_n) begin
        bit flt, us;
        logic [11:0] c;
        logic [31:0] p;
        int n;
        if (!rst_n) begin
            e_valid = 0; e_fault = 0; e_code = 0; e_pa = 0; e_tea = 0; e_urc = 0;
        end else begin
            e_valid = req;
            if (req) begin
                ref_lookup(va, acc_fetch, acc_write, priv_md, at_en, sv_en, cur_asid,
                           flt, c, p, us);
                e_fault = flt; e_code = c; e_pa = p;
                exp_tag = cur_tag;
                if (flt) e_tea = va;
                if (us) begin
                    n = e_urc + 1;
                    if (n == int'(urb) || n == 63) n = 0;
                    e_urc = n;
                end
            end
        end
    end

    task automatic chk(input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", exp_tag, what, act, exp, $time);
        end
    endtask

    // Compare on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            chk("rsp_valid", longint'(rsp_valid), longint'(e_valid));
            chk("tea", longint'(tea), longint'(e_tea));
            chk("urc", longint'(urc), longint'(e_urc));
            if (e_valid || !rst_n) begin
                chk("rsp_fault", longint'(rsp_fault), longint'(e_fault));
                chk("rsp_code", longint'(rsp_code), longint'(e_code));
                chk("rsp_pa", longint'(rsp_pa), longint'(e_pa));
            end
        end
    end

    task automatic look(input logic [31:0] a, input bit f, input bit w, input bit md,
                        input bit at, input bit sv, input logic [7:0] asid, input string tag);
        @(posedge clk); #1;
        req = 1; va = a; acc_fetch = f; acc_write = w; priv_md = md;
        at_en = at; sv_en = sv; cur_asid = asid; cur_tag = tag;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            req = 0;
        end
    endtask

    task automatic set_ent(input int e, input bit v, input bit sh, input bit d,
                           input logic [1:0] sz, input logic [1:0] pr,
                           input logic [7:0] as, input logic [21:0] vpn, input logic [18:0] ppn);
        b_valid[e] = v; b_shared[e] = sh; b_dirty[e] = d; b_size[e] = sz;
        b_pr[e] = pr; b_asid[e] = as; b_vpn[e] = vpn; b_ppn[e] = ppn;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL R12 watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        for (int e = 0; e < N; e++) set_ent(e, 0, 0, 0, 0, 0, 0, 0, 0);
        // e0: 1 KB at 0x4000, ASID 5, read/write, dirty
        set_ent(0, 1, 0, 1, 2'd0, 2'd3, 8'd5, 22'h10, 19'h100);
        // e1: 4 KB at 0x10000, shared, pr 1
        set_ent(1, 1, 1, 1, 2'd1, 2'd1, 8'd9, 22'h40, 19'h200);
        // e2: 64 KB, unaligned VPN/PPN, pr 2, clean
        set_ent(2, 1, 0, 0, 2'd2, 2'd2, 8'd5, 22'h801, 19'h3001);
        // e3: 1 MB at 0x1000000, pr 0, ASID 7
        set_ent(3, 1, 0, 1, 2'd3, 2'd0, 8'd7, 22'h4000, 19'h4000);
        // e5: invalid entry at 0x50000
        set_ent(5, 0, 1, 1, 2'd1, 2'd3, 8'd5, 22'h140, 19'h500);
        // e6: 1 KB overlapping e1 at 0x10400
        set_ent(6, 1, 1, 1, 2'd0, 2'd3, 8'd0, 22'h41, 19'h600);

        repeat (3) @(posedge clk);
        #1 rst_n = 1;               // R12 reset state checked by the compare process
        idle(2);

        // R1 privileged fixed windows
        look(32'h8000_1234, 0, 0, 1, 1, 0, 0, "R1");
        look(32'hA123_4567, 0, 1, 1, 1, 0, 0, "R1");
        look(32'hFF00_0010, 1, 0, 1, 1, 0, 0, "R1");
        // R2 user access to fixed windows
        look(32'h8000_0000, 0, 0, 0, 1, 0, 0, "R2");
        look(32'hBFFF_FFFC, 0, 1, 0, 1, 0, 0, "R2");
        look(32'hE000_0040, 0, 1, 0, 1, 0, 0, "R2");
        look(32'hE400_0000, 0, 0, 0, 1, 0, 0, "R2");
        look(32'hE400_0004, 0, 0, 0, 1, 0, 0, "R2");
        look(32'hDFFF_FFFF, 1, 0, 0, 0, 0, 0, "R2");
        idle(1);
        // R3 translation off
        look(32'h1234_5678, 0, 1, 0, 0, 0, 0, "R3");
        look(32'h7FFF_FFFF, 1, 0, 1, 0, 0, 0, "R3");
        look(32'hC000_1000, 0, 0, 0, 0, 0, 0, "R3");
        // R4 ASID and sharing
        look(32'h0000_4010, 0, 0, 0, 1, 0, 8'd5, "R4");
        look(32'h0000_4010, 0, 0, 0, 1, 0, 8'd6, "R4");
        look(32'h0000_4010, 0, 0, 0, 1, 1, 8'd6, "R4");
        look(32'h0000_4010, 0, 0, 1, 1, 0, 8'd6, "R4");
        look(32'h0001_0008, 0, 0, 0, 1, 0, 8'd33, "R4");
        look(32'h0005_0000, 0, 0, 1, 1, 0, 8'd5, "R4");
        // R5 page sizes and boundaries
        look(32'h0000_43FF, 0, 0, 1, 1, 0, 0, "R5");
        look(32'h0000_4400, 0, 0, 1, 1, 0, 0, "R5");
        look(32'h0000_3FFF, 0, 0, 1, 1, 0, 0, "R5");
        look(32'h0001_0FFF, 0, 0, 1, 1, 0, 0, "R5");
        look(32'h0001_1000, 0, 0, 1, 1, 0, 0, "R5");
        look(32'h0020_0000, 0, 0, 1, 1, 0, 0, "R5");
        look(32'h0020_FFFF, 0, 0, 1, 1, 0, 0, "R5");
        look(32'h0021_0000, 0, 0, 1, 1, 0, 0, "R5");
        look(32'h010F_FFFF, 0, 0, 1, 1, 0, 0, "R5");
        look(32'h0110_0000, 0, 0, 1, 1, 0, 0, "R5");
        // R6 multi-hit
        look(32'h0001_0400, 0, 0, 1, 1, 0, 0, "R6");
        look(32'h0001_07FF, 1, 0, 1, 1, 0, 0, "R6");
        look(32'h0001_0800, 0, 0, 1, 1, 0, 0, "R6");
        idle(2);
        // R7 protection table over all {pr,md}
        for (int md = 0; md < 2; md++) begin
            for (int w = 0; w < 2; w++) begin
                look(32'h0000_4100, 0, w[0], md[0], 1, 0, 8'd5, "R7");
                look(32'h0001_0100, 0, w[0], md[0], 1, 0, 8'd5, "R7");
                look(32'h0020_0100, 0, w[0], md[0], 1, 0, 8'd5, "R7");
                look(32'h0100_0100, 0, w[0], md[0], 1, 0, 8'd7, "R7");
            end
        end
        // R8 instruction fetch privilege
        look(32'h0001_0010, 1, 0, 1, 1, 0, 0, "R8");
        look(32'h0001_0010, 1, 1, 0, 1, 0, 0, "R8");
        look(32'h0000_4004, 1, 1, 1, 1, 0, 0, "R8");
        look(32'h0100_0004, 1, 0, 0, 1, 0, 8'd7, "R8");
        // R9 first write to a clean page
        look(32'h0020_1234, 0, 1, 1, 1, 0, 0, "R9");
        look(32'h0000_4020, 0, 1, 1, 1, 0, 0, "R9");
        b_dirty[2] = 1;
        look(32'h0020_1234, 0, 1, 1, 1, 0, 0, "R9");
        // R10 plain misses
        look(32'h0300_0000, 0, 0, 1, 1, 0, 0, "R10");
        look(32'h0300_0000, 0, 1, 1, 1, 0, 0, "R10");
        look(32'h0300_0000, 1, 1, 1, 1, 0, 0, "R10");
        idle(3);
        // R11 replacement pointer: wrap at 63, then at the boundary
        urb = 6'd0;
        for (int i = 0; i < 70; i++) look(32'h0000_4000, 0, 0, 1, 1, 0, 0, "R11");
        look(32'h0000_4000, 1, 0, 1, 1, 0, 0, "R11");
        look(32'h8000_4000, 0, 0, 1, 1, 0, 0, "R11");
        look(32'h0000_4000, 0, 0, 1, 0, 0, 0, "R11");
        urb = 6'd5;
        for (int i = 0; i < 12; i++) look(32'h0300_0000, 0, i[0], 1, 1, 0, 0, "R11");
        idle(2);
        // R12 hold across gaps and back-to-back faults
        look(32'h0300_0040, 0, 0, 1, 1, 0, 0, "R12");
        idle(3);
        look(32'h8000_0000, 0, 0, 1, 1, 0, 0, "R12");
        look(32'h0300_0080, 0, 1, 1, 1, 0, 0, "R12");
        idle(4);
        finish_run();
    end
endmodule